// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block gathers a set of external interrupt sources and hands them out to a set of targets called contexts. A context is one privilege mode of one hardware thread. Every source passes through a gateway, which turns an edge or a level into a single pending request and then holds the source until the handler reports it finished. Each source carries a programmable priority. Each context has its own enable mask over the sources and its own priority threshold. The block raises one interrupt line per context whenever an eligible request waits for it.

A context takes work with a claim and hands it back with a complete. A claim is a valid/ready handshake. `claim_ready` goes high for the lowest-numbered context that asserts `claim_valid`, so only one claim is accepted per cycle. The other requesters hold `claim_valid` until they are served, and while they wait they see back-pressure. In the cycle after the handshake, the context's `claim_id` field shows the winning source ID, or 0 when nothing was eligible. The field keeps that value until the context's next accepted claim. A complete is a plain one-cycle strobe with an ID and is never back-pressured. Configuration uses a flat synchronous register port. A write takes effect at the clock edge, and a read returns the addressed register combinationally.

Top module: `plic_top`

## Requirements
- R1: Each source has a separate enable bit for each context. A source raises `irq[c]`, and a claim by context c can return it, only when its enable bit for c is set.
- R2: Among the sources eligible for a context, a claim returns the one with the highest priority value. When priorities are equal, the lowest source ID wins.
- R3: A source is eligible for context c only if its priority is strictly greater than that context's threshold. A source whose priority is 0 therefore never interrupts.
- R4: `irq[c]` is high exactly while at least one source is eligible for c. An accepted claim returns the chosen ID and clears that source's pending state in the same cycle. A claim with no eligible source returns 0, which means no interrupt.
- R5: After a source is claimed, its gateway accepts no new request from it until a matching complete arrives. In edge mode, one rising edge gives one request. Further edges while the request is pending merge into it, and edges that arrive while the source is in service are dropped.
- R6: In level mode, a source whose input is still high when it is completed becomes pending again one cycle after the complete.
- R7: A complete is ignored when its ID is 0 or above the source count, or when that source is not enabled for the completing context. The source then stays in service.
- R8: At most one claim is accepted per cycle. `claim_ready[c]` is high only when `claim_valid[c]` is high and no lower-numbered context is requesting. `claim_id` is updated on the clock edge that accepts the claim.
- R9: The configuration address is {region[1:0], index}. Region 0 holds the priority of source `index` (IDs 1..NSRC). Region 1 holds the threshold of context `index`. Region 2 holds the enable mask of context `index`, with bit s meaning source s. Region 3 holds the trigger mask, with bit s = 1 meaning edge mode and 0 meaning level mode. Writes to indices out of range are dropped, and reads from them return 0.
- R10: Reset clears every priority, threshold, enable bit, trigger bit, pending request and in-service mark. All `irq` lines are low and all `claim_id` fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2+IXW | Region and index |
| cfg_wdata | input | DW | Write data |
| cfg_rdata | output | DW | Read data for `cfg_addr` |
| src_irq | input | NSRC | Source inputs, bit s is source ID s |
| irq | output | NCTX | Interrupt line per context |
| claim_valid | input | NCTX | Claim request per context |
| claim_ready | output | NCTX | Claim accepted this cycle |
| claim_id | output | NCTX*ID_W | Last claimed ID per context |
| cmp_valid | input | NCTX | Complete strobe per context |
| cmp_id | input | NCTX*ID_W | ID being completed per context |

## Verification
The hardest states to reach are the gateway's in-service window and a rejected complete. Reaching them takes a claim, then a level input that stays high or an edge that arrives during service, and then a complete that the block must refuse because it is from the wrong context or carries an out-of-range ID. The bench first sweeps every source through every priority value against a fixed threshold. It then pulses all sources in edge mode with computed priorities and drains them claim by claim against an arithmetic arbitration model. Directed sequences follow for merged edges, dropped edges, level re-arming, refused completes and two contexts claiming in the same cycle.

// File: rtl/plic_pkg.sv
package plic_pkg;
  typedef enum logic [1:0] {
    RG_PRIO = 2'd0,
    RG_THR  = 2'd1,
    RG_EN   = 2'd2,
    RG_TRIG = 2'd3
  } cfg_region_e;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic edge_mode,
  input  logic claim,
  input  logic complete,
  output logic pending
);
  logic busy, prev;
  logic req;

  always_comb req = edge_mode ? (src & ~prev) : src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      busy    <= 1'b0;
      prev    <= 1'b0;
    end else begin
      prev <= src;
      if (claim) begin
        pending <= 1'b0;
        busy    <= 1'b1;
      end else begin
        if (complete) busy <= 1'b0;
        if (req && !busy) pending <= 1'b1;
      end
    end
  end

  assert_pend_busy_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && busy));
  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !complete) |=> busy);
  assert_claim_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> !pending);
endmodule

// File: rtl/plic_selector.sv
module plic_selector #(
  parameter int NSRC = 10,
  parameter int PW   = 3,
  parameter int ID_W = 4
) (
  input  logic [NSRC:1]         pend,
  input  logic [NSRC:1]         en,
  input  logic [NSRC:1][PW-1:0] prio,
  input  logic [PW-1:0]         thr,
  output logic                  irq,
  output logic [ID_W-1:0]       best_id
);
  logic [NSRC:1] elig;
  logic [PW-1:0] best_p;

  always_comb begin
    for (int s = 1; s <= NSRC; s++)
      elig[s] = pend[s] && en[s] && (prio[s] > thr);
    irq = |elig;
  end

  always_comb begin
    best_id = '0;
    best_p  = '0;
    for (int s = NSRC; s >= 1; s--) begin
      if (elig[s] && prio[s] >= best_p) begin
        best_id = ID_W'(s);
        best_p  = prio[s];
      end
    end
  end

  always_comb begin
    assert_irq_matches_best_R4: assert (irq == (best_id != '0));
  end
endmodule

// File: rtl/plic_cfg.sv
module plic_cfg
  import plic_pkg::*;
#(
  parameter int NSRC = 10,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int DW   = 32,
  parameter int IXW  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [IXW+1:0]                 addr,
  input  logic [DW-1:0]                  wdata,
  output logic [DW-1:0]                  rdata,
  output logic [NSRC:1][PW-1:0]          prio,
  output logic [NCTX-1:0][PW-1:0]        thr,
  output logic [NCTX-1:0][NSRC:1]        en,
  output logic [NSRC:1]                  edge_mode
);
  cfg_region_e   region;
  logic [IXW-1:0] idx;

  always_comb begin
    region = cfg_region_e'(addr[IXW+1:IXW]);
    idx    = addr[IXW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio      <= '0;
      thr       <= '0;
      en        <= '0;
      edge_mode <= '0;
    end else if (we) begin
      case (region)
        RG_PRIO: for (int s = 1; s <= NSRC; s++)
                   if (int'(idx) == s) prio[s] <= wdata[PW-1:0];
        RG_THR:  for (int c = 0; c < NCTX; c++)
                   if (int'(idx) == c) thr[c] <= wdata[PW-1:0];
        RG_EN:   for (int c = 0; c < NCTX; c++)
                   if (int'(idx) == c) en[c] <= wdata[NSRC:1];
        default: edge_mode <= wdata[NSRC:1];
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (region)
      RG_PRIO: for (int s = 1; s <= NSRC; s++)
                 if (int'(idx) == s) rdata[PW-1:0] = prio[s];
      RG_THR:  for (int c = 0; c < NCTX; c++)
                 if (int'(idx) == c) rdata[PW-1:0] = thr[c];
      RG_EN:   for (int c = 0; c < NCTX; c++)
                 if (int'(idx) == c) rdata[NSRC:1] = en[c];
      default: rdata[NSRC:1] = edge_mode;
    endcase
  end
endmodule

// File: rtl/plic_top.sv
module plic_top #(
  parameter int NSRC  = 10,
  parameter int NCTX  = 2,
  parameter int PW    = 3,
  parameter int DW    = 32,
  parameter int ID_W  = $clog2(NSRC + 1),
  parameter int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1,
  parameter int IXW   = (ID_W > CTX_W) ? ID_W : CTX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IXW+1:0]       cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  output logic [DW-1:0]        cfg_rdata,
  input  logic [NSRC:1]        src_irq,
  output logic [NCTX-1:0]      irq,
  input  logic [NCTX-1:0]      claim_valid,
  output logic [NCTX-1:0]      claim_ready,
  output logic [NCTX*ID_W-1:0] claim_id,
  input  logic [NCTX-1:0]      cmp_valid,
  input  logic [NCTX*ID_W-1:0] cmp_id
);
  logic [NSRC:1][PW-1:0]     prio;
  logic [NCTX-1:0][PW-1:0]   thr;
  logic [NCTX-1:0][NSRC:1]   en;
  logic [NSRC:1]             edge_mode;
  logic [NSRC:1]             pend;
  logic [NSRC:1]             claim_hit, cmp_hit;
  logic [NCTX-1:0][ID_W-1:0] best;

  plic_cfg #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .DW(DW), .IXW(IXW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .prio(prio), .thr(thr), .en(en), .edge_mode(edge_mode)
  );

  for (genvar s = 1; s <= NSRC; s++) begin : g_gw
    plic_gateway u_gw (
      .clk(clk), .rst_n(rst_n), .src(src_irq[s]), .edge_mode(edge_mode[s]),
      .claim(claim_hit[s]), .complete(cmp_hit[s]), .pending(pend[s])
    );
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    plic_selector #(.NSRC(NSRC), .PW(PW), .ID_W(ID_W)) u_sel (
      .pend(pend), .en(en[c]), .prio(prio), .thr(thr[c]),
      .irq(irq[c]), .best_id(best[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) claim_id[c*ID_W +: ID_W] <= '0;
      else if (claim_ready[c]) claim_id[c*ID_W +: ID_W] <= best[c];
    end

    assert_ready_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      claim_ready[c] |-> claim_valid[c]);
    assert_grant_loads_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_ready[c] && !irq[c]) |=> (claim_id[c*ID_W +: ID_W] == '0));
  end

  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int c = 0; c < NCTX; c++) begin
      claim_ready[c] = claim_valid[c] && !taken;
      taken = taken | claim_valid[c];
    end
  end

  always_comb begin
    claim_hit = '0;
    cmp_hit   = '0;
    for (int c = 0; c < NCTX; c++)
      for (int s = 1; s <= NSRC; s++) begin
        if (claim_ready[c] && best[c] == ID_W'(s)) claim_hit[s] = 1'b1;
        if (cmp_valid[c] && cmp_id[c*ID_W +: ID_W] == ID_W'(s) && en[c][s])
          cmp_hit[s] = 1'b1;
      end
  end

  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_ready));
endmodule

// File: tb/plic_top_tb.sv
module plic_top_tb;
  localparam int NSRC = 10, NCTX = 2, PW = 3, DW = 32, ID_W = 4, IXW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IXW+1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic [NSRC:1] src_irq = '0;
  logic [NCTX-1:0] irq, claim_valid = '0, claim_ready, cmp_valid = '0;
  logic [NCTX*ID_W-1:0] claim_id, cmp_id = '0;
  int errors = 0, checks = 0;
  bit done = 0;
  localparam logic [DW-1:0] ALL = ((DW'(1) << NSRC) - 1) << 1;

  always #2 clk = ~clk;

  plic_top #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_irq(src_irq), .irq(irq),
    .claim_valid(claim_valid), .claim_ready(claim_ready), .claim_id(claim_id),
    .cmp_valid(cmp_valid), .cmp_id(cmp_id)
  );

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int rg, input int idx, input logic [DW-1:0] d);
    cfg_we = 1'b1; cfg_addr = {2'(rg), 4'(idx)}; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input int rg, input int idx, input int exp, input string req);
    cfg_addr = {2'(rg), 4'(idx)};
    #1;
    chk(cfg_rdata == DW'(exp), req, int'(cfg_rdata), exp);
  endtask

  task automatic claim(input int c, output int id);
    claim_valid[c] = 1'b1;
    #1;
    while (!claim_ready[c]) tick();
    tick();
    claim_valid[c] = 1'b0;
    id = int'(claim_id[c*ID_W +: ID_W]);
  endtask

  task automatic complete(input int c, input int id);
    cmp_valid[c] = 1'b1; cmp_id[c*ID_W +: ID_W] = ID_W'(id);
    tick();
    cmp_valid[c] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int id, exp, bp;
    bit [NSRC:1] taken;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk(irq == '0, "R10", int'(irq), 0);
    chk(claim_id == '0, "R10", int'(claim_id), 0);
    rd_chk(0, 1, 0, "R10");
    rd_chk(2, 0, 0, "R10");

    // R9 register map readback
    for (int s = 1; s <= NSRC; s++) wr(0, s, DW'(s % 8));
    for (int s = 1; s <= NSRC; s++) rd_chk(0, s, s % 8, "R9");
    wr(0, 11, 7);
    rd_chk(0, 11, 0, "R9");
    rd_chk(0, 0, 0, "R9");
    wr(1, 1, 5);
    rd_chk(1, 1, 5, "R9");
    wr(2, 1, 32'h0000_0014);
    rd_chk(2, 1, 32'h14, "R9");
    wr(3, 0, 32'h0000_0006);
    rd_chk(3, 0, 6, "R9");
    for (int s = 1; s <= NSRC; s++) wr(0, s, 0);
    wr(1, 1, 0); wr(2, 1, 0); wr(3, 0, 0);

    // R3 sweep: every source, every priority, threshold 3, level mode
    wr(1, 0, 3);
    wr(2, 0, ALL);
    for (int s = 1; s <= NSRC; s++) begin
      src_irq[s] = 1'b1;
      for (int p = 0; p < 8; p++) begin
        wr(0, s, DW'(p));
        chk(irq[0] == (p > 3), "R3", int'(irq[0]), int'(p > 3));
        if (p == 0) chk(irq[1] == 1'b0, "R1", int'(irq[1]), 0);
      end
      claim(0, id);
      chk(id == s, "R4", id, s);
      chk(irq[0] == 1'b0, "R4", int'(irq[0]), 0);
      src_irq[s] = 1'b0;
      complete(0, s);
      wr(0, s, 0);
    end

    // R2 arbitration: all edge, computed priorities, drain
    wr(1, 0, 0);
    wr(3, 0, ALL);
    for (int s = 1; s <= NSRC; s++) wr(0, s, DW'((s * 5) % 8));
    src_irq = '1; tick(); src_irq = '0; tick();
    taken = '0;
    for (int k = 0; k < NSRC - 1; k++) begin
      exp = 0; bp = 0;
      for (int s = 1; s <= NSRC; s++)
        if (!taken[s] && ((s * 5) % 8) > bp) begin exp = s; bp = (s * 5) % 8; end
      claim(0, id);
      chk(id == exp, "R2", id, exp);
      if (exp != 0) taken[exp] = 1'b1;
    end
    claim(0, id);
    chk(id == 0, "R4", id, 0);
    chk(irq[0] == 1'b0, "R4", int'(irq[0]), 0);
    for (int s = 1; s <= NSRC; s++) if (taken[s]) complete(0, s);
    for (int s = 1; s <= NSRC; s++) wr(0, s, 0);

    // R5 edge merging and dropping; R6 level re-arm
    wr(3, 0, ALL & ~DW'(4));
    wr(0, 1, 1); wr(0, 2, 2);
    src_irq[1] = 1; tick(); src_irq[1] = 0; tick();
    src_irq[1] = 1; tick(); src_irq[1] = 0; tick();
    chk(irq[0] == 1'b1, "R5", int'(irq[0]), 1);
    claim(0, id);
    chk(id == 1, "R5", id, 1);
    complete(0, 1); tick();
    chk(irq[0] == 1'b0, "R5", int'(irq[0]), 0);
    claim(0, id);
    chk(id == 0, "R5", id, 0);
    src_irq[1] = 1; tick(); src_irq[1] = 0; tick();
    claim(0, id);
    chk(id == 1, "R5", id, 1);
    src_irq[1] = 1; tick(); src_irq[1] = 0; tick();
    complete(0, 1); tick();
    chk(irq[0] == 1'b0, "R5", int'(irq[0]), 0);
    src_irq[2] = 1; tick();
    claim(0, id);
    chk(id == 2, "R6", id, 2);
    tick(); tick();
    chk(irq[0] == 1'b0, "R5", int'(irq[0]), 0);
    complete(0, 2); tick();
    chk(irq[0] == 1'b1, "R6", int'(irq[0]), 1);
    claim(0, id);
    chk(id == 2, "R6", id, 2);
    src_irq[2] = 0;
    complete(0, 2); tick();
    chk(irq[0] == 1'b0, "R6", int'(irq[0]), 0);
    wr(0, 1, 0); wr(0, 2, 0);

    // R1 routing to one context, R7 refused completes
    wr(3, 0, 0);
    wr(0, 3, 5);
    wr(2, 0, 0); wr(2, 1, 32'h8);
    src_irq[3] = 1; tick();
    chk(irq[0] == 1'b0, "R1", int'(irq[0]), 0);
    chk(irq[1] == 1'b1, "R1", int'(irq[1]), 1);
    claim(0, id);
    chk(id == 0, "R1", id, 0);
    claim(1, id);
    chk(id == 3, "R1", id, 3);
    complete(0, 3); tick(); tick();
    chk(irq[1] == 1'b0, "R7", int'(irq[1]), 0);
    complete(1, 15); tick(); tick();
    chk(irq[1] == 1'b0, "R7", int'(irq[1]), 0);
    complete(1, 3); tick();
    chk(irq[1] == 1'b1, "R7", int'(irq[1]), 1);
    claim(1, id);
    chk(id == 3, "R7", id, 3);
    src_irq[3] = 0;
    complete(1, 3);
    wr(0, 3, 0);

    // R8 simultaneous claims
    wr(0, 4, 6);
    wr(2, 0, 32'h10); wr(2, 1, 32'h10);
    src_irq[4] = 1; tick();
    claim_valid = 2'b11; #1;
    chk(claim_ready == 2'b01, "R8", int'(claim_ready), 1);
    tick();
    claim_valid = 2'b00;
    chk(claim_id[ID_W-1:0] == 4, "R8", int'(claim_id[ID_W-1:0]), 4);
    chk(claim_id[2*ID_W-1:ID_W] == 3, "R8", int'(claim_id[2*ID_W-1:ID_W]), 3);
    claim(1, id);
    chk(id == 0, "R8", id, 0);
    src_irq[4] = 0;
    complete(0, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule